// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the control side of a multi-channel successive-approximation ADC that runs in scan mode. Software programs one configuration register over a simple write/read bus. The register picks the conversion rate, whether sample-and-hold is used, how fast that sample-and-hold runs, and the highest channel of the scan loop. A start pulse then makes the sequencer walk the analog multiplexer from channel 0 upward to the programmed last channel. For each channel it issues a conversion request to the converter core and waits for the core's done pulse before it moves on.

A 2-bit speed/method code goes to the core with every channel. The code is taken from the register when the scan starts, so software may reprogram the register during a scan without disturbing it. While a scan runs, the loop field of the register reads back the channel being converted. In continuous mode the loop repeats from channel 0 until continuous mode is dropped.

Top module: `adcScanSeq`

## Requirements
- R1: After reset, cfgRdata is 0x00, and chanSel, speedCode, convReq, scanBusy and scanDone are all 0.
- R2: Register bit 0 has no function. It always reads 0, and a 1 written to it is dropped.
- R3: The register holds double speed in bit 1, sample-and-hold enable in bit 2 and fast sample-and-hold in bit 3. speedCode is 00 for normal without sample-and-hold, 01 for double speed, 10 for normal sample-and-hold and 11 for fast sample-and-hold. Sample-and-hold takes priority over double speed. Bit 3 counts only when bit 2 is 1; otherwise it is treated as 0.
- R4: Bits 7:4 hold the loop field. A value N makes a scan convert channels 0 to N inclusive, in ascending order, presented on chanSel.
- R5: While scanBusy is 1, cfgRdata[7:4] returns the channel being converted. While idle, it returns the last value written.
- R6: In the cycle after a clock edge that sees scanStart while idle, scanBusy and convReq are 1 and chanSel is 0. In the cycle after an edge that sees coreDone while busy on a channel other than the last, chanSel has stepped by one and convReq pulses for one cycle.
- R7: A coreDone on the last channel with contMode low gives a one-cycle scanDone in the next cycle, and scanBusy drops in that same cycle. chanSel keeps the last channel.
- R8: A coreDone on the last channel with contMode high gives a one-cycle scanDone, keeps scanBusy high, returns chanSel to 0 and issues a new convReq.
- R9: A register write during a scan changes neither the running scan's speedCode nor its last channel. The new contents apply from the next start.
- R10: scanStart while busy has no effect, and coreDone while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgWdata | input | 4+CHAN_W | Register write data |
| cfgRdata | output | 4+CHAN_W | Register read data |
| scanStart | input | 1 | Start pulse for a scan |
| contMode | input | 1 | Repeat the loop when the last channel completes |
| coreDone | input | 1 | Conversion-finished pulse from the converter core |
| chanSel | output | CHAN_W | Analog multiplexer channel select |
| speedCode | output | 2 | Speed/method code to the converter core |
| convReq | output | 1 | One-cycle conversion request per channel |
| scanBusy | output | 1 | High while a scan is running |
| scanDone | output | 1 | One-cycle pulse when a loop pass ends |

## Verification
The bench builds the block with CHAN_W = 4. That default gives the full sixteen-channel range, so a loop field of 15 is reachable: the scan must cover every multiplexer position, and the channel counter meets its top value without wrapping early. A loop field of 0 exercises the single-channel scan, where the first done pulse is also the last one. The converter stub answers each request after a latency that varies from one to several cycles. This lets done pulses arrive close behind a request, and lets register writes and redundant starts fall in the middle of a scan.

// File: rtl/adcScanPkg.sv
package adcScanPkg;

  localparam int unsigned RSVD_BIT    = 0;
  localparam int unsigned DOUBLE_BIT  = 1;
  localparam int unsigned SH_EN_BIT   = 2;
  localparam int unsigned SH_FAST_BIT = 3;
  localparam int unsigned LOOP_LSB    = 4;

  typedef struct packed {
    logic loadCfg;
    logic clearChan;
    logic incChan;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    CODE_NORMAL  = 2'b00,
    CODE_DOUBLE  = 2'b01,
    CODE_SH      = 2'b10,
    CODE_SH_FAST = 2'b11
  } speedCode_t;

  function automatic speedCode_t encodeSpeed(input logic dbl, input logic shEn, input logic shFast);
    if (shEn) return shFast ? CODE_SH_FAST : CODE_SH;
    return dbl ? CODE_DOUBLE : CODE_NORMAL;
  endfunction

endpackage

// File: rtl/adcScanRegs.sv
module adcScanRegs
  import adcScanPkg::*;
#(
  parameter int unsigned CHAN_W = 4,
  localparam int unsigned REG_W = LOOP_LSB + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  input  seqStrobe_t        strobe,
  input  logic              scanBusy,
  output logic [REG_W-1:0]  cfgRdata,
  output logic [CHAN_W-1:0] chanSel,
  output logic [1:0]        speedCode,
  output logic              isLast
);

  localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << RSVD_BIT);

  logic [REG_W-1:0]  cfgReg;
  logic [CHAN_W-1:0] lastChan;
  logic [CHAN_W-1:0] curChan;
  speedCode_t        codeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWe) begin
      cfgReg <= cfgWdata & WR_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastChan <= '0;
      codeReg  <= CODE_NORMAL;
    end else if (strobe.loadCfg) begin
      lastChan <= cfgReg[REG_W-1:LOOP_LSB];
      codeReg  <= encodeSpeed(cfgReg[DOUBLE_BIT], cfgReg[SH_EN_BIT], cfgReg[SH_FAST_BIT]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curChan <= '0;
    end else if (strobe.clearChan) begin
      curChan <= '0;
    end else if (strobe.incChan) begin
      curChan <= curChan + CHAN_W'(1);
    end
  end

  always_comb begin
    cfgRdata = cfgReg;
    if (scanBusy) cfgRdata[REG_W-1:LOOP_LSB] = curChan;
  end

  assign chanSel   = curChan;
  assign speedCode = codeReg;
  assign isLast    = (curChan == lastChan);

endmodule

// File: rtl/adcScanCtrl.sv
module adcScanCtrl
  import adcScanPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scanStart,
  input  logic       coreDone,
  input  logic       contMode,
  input  logic       isLast,
  output seqStrobe_t strobe,
  output logic       scanBusy,
  output logic       convReq,
  output logic       scanDone
);

  typedef enum logic {S_IDLE, S_RUN} seqState_t;

  seqState_t state;
  logic      startNow;
  logic      advance;
  logic      passEnd;
  logic      wrapNow;
  logic      stopNow;

  assign startNow = (state == S_IDLE) && scanStart;
  assign advance  = (state == S_RUN) && coreDone;
  assign passEnd  = advance && isLast;
  assign wrapNow  = passEnd && contMode;
  assign stopNow  = passEnd && !contMode;

  always_comb begin
    strobe.loadCfg   = startNow;
    strobe.clearChan = startNow || wrapNow;
    strobe.incChan   = advance && !isLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      convReq  <= 1'b0;
      scanDone <= 1'b0;
    end else begin
      if (startNow)     state <= S_RUN;
      else if (stopNow) state <= S_IDLE;
      convReq  <= startNow || (advance && !stopNow);
      scanDone <= passEnd;
    end
  end

  assign scanBusy = (state == S_RUN);

endmodule

// File: rtl/adcScanSeq.sv
module adcScanSeq
  import adcScanPkg::*;
#(
  parameter int unsigned CHAN_W = 4,
  localparam int unsigned REG_W = LOOP_LSB + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              scanStart,
  input  logic              contMode,
  input  logic              coreDone,
  output logic [CHAN_W-1:0] chanSel,
  output logic [1:0]        speedCode,
  output logic              convReq,
  output logic              scanBusy,
  output logic              scanDone
);

  seqStrobe_t strobe;
  logic       isLast;

  adcScanCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .scanStart(scanStart),
    .coreDone (coreDone),
    .contMode (contMode),
    .isLast   (isLast),
    .strobe   (strobe),
    .scanBusy (scanBusy),
    .convReq  (convReq),
    .scanDone (scanDone)
  );

  adcScanRegs #(.CHAN_W(CHAN_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .strobe   (strobe),
    .scanBusy (scanBusy),
    .cfgRdata (cfgRdata),
    .chanSel  (chanSel),
    .speedCode(speedCode),
    .isLast   (isLast)
  );

endmodule

// File: rtl/adcScanChecker.sv
module adcScanChecker #(
  parameter int unsigned CHAN_W = 4,
  localparam int unsigned REG_W = 4 + CHAN_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_W-1:0]  cfgRdata,
  input logic              scanStart,
  input logic              coreDone,
  input logic [CHAN_W-1:0] chanSel,
  input logic              convReq,
  input logic              scanBusy,
  input logic              scanDone
);

  a_r2_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[0] == 1'b0);

  a_r5_loop_reads_channel: assert property (@(posedge clk) disable iff (!rstN)
    scanBusy |-> (cfgRdata[REG_W-1:4] == chanSel));

  a_r6_start_launches: assert property (@(posedge clk) disable iff (!rstN)
    (!scanBusy && scanStart) |=> (scanBusy && convReq && chanSel == '0));

  a_r6_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> scanBusy);

  a_r4_ascending_step: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && $past(scanBusy) && !scanDone) |-> (chanSel == $past(chanSel) + CHAN_W'(1)));

  a_r7_stop_flags_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scanBusy) |-> scanDone);

  a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (scanBusy && scanStart && !coreDone) |=> $stable(chanSel));

endmodule

bind adcScanSeq adcScanChecker #(.CHAN_W(CHAN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgRdata (cfgRdata),
  .scanStart(scanStart),
  .coreDone (coreDone),
  .chanSel  (chanSel),
  .convReq  (convReq),
  .scanBusy (scanBusy),
  .scanDone (scanDone)
);

// File: tb/test_adcScanSeq.sv
module test_adcScanSeq;

  localparam int CHAN_W = 4;
  localparam int REG_W  = 4 + CHAN_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [REG_W-1:0]  cfgWdata = '0;
  logic [REG_W-1:0]  cfgRdata;
  logic              scanStart = 1'b0;
  logic              contMode = 1'b0;
  logic              coreDone = 1'b0;
  logic [CHAN_W-1:0] chanSel;
  logic [1:0]        speedCode;
  logic              convReq;
  logic              scanBusy;
  logic              scanDone;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase  = "R1 reset";

  // converter stub controls
  bit stubOn  = 1'b1;
  int stubLat = 1;
  int stubCnt = 0;

  // reference model state
  bit         mBusy = 0;
  bit         mReq  = 0;
  bit         mDone = 0;
  int         mChan = 0;
  int         mLast = 0;
  int         mCode = 0;
  logic [7:0] mCfg  = '0;

  always #2 clk = ~clk;  // 250 MHz

  adcScanSeq #(.CHAN_W(CHAN_W)) i_adcScanSeq (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .scanStart(scanStart), .contMode(contMode), .coreDone(coreDone), .chanSel(chanSel),
    .speedCode(speedCode), .convReq(convReq), .scanBusy(scanBusy), .scanDone(scanDone)
  );

  function automatic int codeOf(logic [7:0] c);
    if (c[2]) return c[3] ? 3 : 2;
    return c[1] ? 1 : 0;
  endfunction

  // behavioural reference, updated on the active edge
  always @(posedge clk) begin
    logic [7:0] oldCfg;
    oldCfg = mCfg;
    if (!rstN) begin
      mBusy = 0; mReq = 0; mDone = 0; mChan = 0; mLast = 0; mCode = 0; mCfg = '0;
    end else begin
      if (cfgWe) mCfg = cfgWdata & 8'hFE;
      mReq = 0; mDone = 0;
      if (!mBusy) begin
        if (scanStart) begin
          mBusy = 1; mChan = 0; mLast = oldCfg[7:4]; mCode = codeOf(oldCfg); mReq = 1;
        end
      end else if (coreDone) begin
        if (mChan == mLast) begin
          mDone = 1;
          if (contMode) begin mChan = 0; mReq = 1; end
          else mBusy = 0;
        end else begin
          mChan = mChan + 1; mReq = 1;
        end
      end
    end
  end

  task automatic cmp(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", phase, name, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      cmp("cfgRdata(R5)", int'(cfgRdata), mBusy ? int'({mChan[3:0], mCfg[3:0]}) : int'(mCfg));
      cmp("chanSel(R4)", int'(chanSel), mChan);
      cmp("speedCode(R3)", int'(speedCode), mCode);
      cmp("convReq(R6)", int'(convReq), int'(mReq));
      cmp("scanDone(R7)", int'(scanDone), int'(mDone));
      cmp("scanBusy(R10)", int'(scanBusy), int'(mBusy));
    end
  end

  // converter stub: done pulse stubLat cycles after each request
  always @(negedge clk) begin
    if (stubOn) begin
      coreDone = 1'b0;
      if (stubCnt > 0) begin
        stubCnt--;
        if (stubCnt == 0) coreDone = 1'b1;
      end
      if (convReq) begin
        stubCnt = stubLat;
        stubLat = (stubLat % 4) + 1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog in phase %s actual %0d expected below 100000", phase, cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic writeCfg(logic [7:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); scanStart = 1'b1;
    @(negedge clk); scanStart = 1'b0;
  endtask

  task automatic waitScanDone();
    @(negedge clk);
    while (!scanDone) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    cmp("cfgRdata(R1)", int'(cfgRdata), 0);
    cmp("chanSel(R1)", int'(chanSel), 0);
    cmp("speedCode(R1)", int'(speedCode), 0);
    cmp("flags(R1)", int'({convReq, scanBusy, scanDone}), 0);
    rstN = 1'b1;

    phase = "R2 reserved bit";
    writeCfg(8'h3B);
    cmp("cfgRdata(R2)", int'(cfgRdata), 8'h3A);

    phase = "R3 double speed, fast bit ignored, loop 3";
    pulseStart();
    cmp("speedCode(R3)", int'(speedCode), 1);
    waitScanDone();

    phase = "R4 single channel, fast sample-and-hold";
    writeCfg(8'h0C);
    pulseStart();
    cmp("speedCode(R3)", int'(speedCode), 3);
    waitScanDone();

    phase = "R4 full sixteen-channel loop, normal sample-and-hold";
    writeCfg(8'hF4);
    pulseStart();
    waitScanDone();
    cmp("chanSel(R4) held at last", int'(chanSel), 15);

    phase = "R8 continuous wrap";
    writeCfg(8'h20);
    contMode = 1'b1;
    pulseStart();
    waitScanDone();
    waitScanDone();
    cmp("scanBusy(R8) after wrap", int'(scanBusy), 1);
    contMode = 1'b0;
    waitScanDone();

    phase = "R9 write during scan";
    writeCfg(8'h34);
    pulseStart();
    writeCfg(8'h1A);
    cmp("speedCode(R9) unchanged", int'(speedCode), 2);
    phase = "R10 start while busy";
    pulseStart();
    waitScanDone();
    phase = "R9 new config at next start";
    pulseStart();
    cmp("speedCode(R9) new", int'(speedCode), 1);
    waitScanDone();

    phase = "R10 done while idle";
    stubOn = 1'b0;
    @(negedge clk); coreDone = 1'b1;
    @(negedge clk); coreDone = 1'b0;
    cmp("scanBusy(R10) idle", int'(scanBusy), 0);
    cmp("convReq(R10) idle", int'(convReq), 0);
    stubOn = 1'b1;
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule